// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a host processor by watching the traffic it makes on a two-wire serial bus. A millisecond tick advances a counter, and the host proves it is alive by starting bus transfers. The restart event is the first falling edge of the clock line after a START condition. A START is the data line falling while the clock line is high. If no restart arrives before the selected timeout, the active-low timeout output is driven low. It stays low until the host restarts the counter.

A two-bit period code selects one of three timeout lengths, or turns the watchdog off. Each length is a count of ticks. The code takes effect only when a complete bus command ends with a STOP condition, which is the data line rising while the clock line is high. After reset the watchdog is off. While the system runs from its backup battery, the time base halts and the count is frozen. Timeout lengths are parameters, so a simulation can use shorter periods.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, `wdo_n` is 1 and the active period code is 2'b11 (off). Ticks then leave `wdo_n` at 1, whatever `period_code` is driven, until a STOP has been seen.
- R2: With active code 2'b00, `wdo_n` falls after exactly `T_LONG` counted ticks following a restart, and not before.
- R3: With active code 2'b01, `wdo_n` falls after exactly `T_MID` counted ticks following a restart.
- R4: With active code 2'b10, `wdo_n` falls after exactly `T_SHORT` counted ticks following a restart.
- R5: With active code 2'b11, the counter is held at zero and `wdo_n` stays 1 however many ticks arrive.
- R6: The first `scl` high-to-low transition after a START (`sda` falling while `scl` is high) clears the count to zero and returns `wdo_n` to 1.
- R7: Further `scl` falling edges in the same transfer, before another START, do not restart the count.
- R8: An `scl` falling edge with no START before it does not restart the count. `sda` falling while `scl` is low is not a START.
- R9: Ticks that arrive while `on_battery` is 1 are not counted. Counting resumes from the frozen value when `on_battery` returns to 0.
- R10: A new value on `period_code` is loaded into the active code only on a STOP (`sda` rising while `scl` is high). Until then the previous active code governs the timeout.
- R11: Once low, `wdo_n` stays low through further ticks until a restart event or the off code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle time-base pulse, nominally once per millisecond |
| scl | input | 1 | Serial clock line, already synchronized to `clk` |
| sda | input | 1 | Serial data line, already synchronized to `clk` |
| on_battery | input | 1 | 1 while the system runs from battery backup |
| period_code | input | 2 | Requested period code from the control register: 00 long, 01 mid, 10 short, 11 off |
| wdo_n | output | 1 | Active-low watchdog timeout, registered |

## Verification
The bench targets the exact expiry tick for every period code. It checks one tick short of the limit and then at the limit, so an off-by-one counter fails at one of the two points. It sends clock-line falls that are not the first after a START, and a data fall while the clock is low. A detector that treats any clock fall as a restart, or that takes a data fall with the clock low as a START, would raise `wdo_n` wrongly there. It changes the period code without a STOP, and a design that loads the code at once would expire early. It sends ticks while on battery, and a design that counts them would expire too soon after the supply returns.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } period_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bwd_bus_events.sv
// Samples the synchronized bus lines, finds START/STOP and the restart edge.
module bwd_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic kick,
  output logic stop_seen
);

  logic scl_q, sda_q;
  logic armed;
  logic start_now, stop_now, scl_fall;

  // Compare the live lines against the previous cycle's sample.
  assign start_now = scl && scl_q && sda_q && !sda;
  assign stop_now  = scl && scl_q && !sda_q && sda;
  assign scl_fall  = scl_q && !scl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      armed     <= 1'b0;
      kick      <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      scl_q     <= scl;
      sda_q     <= sda;
      kick      <= armed && scl_fall;
      stop_seen <= stop_now;
      if (start_now)
        armed <= 1'b1;
      else if (scl_fall || stop_now)
        armed <= 1'b0;
    end
  end

endmodule

// File: rtl/bwd_period_hold.sv
// Holds the period code in force; a requested code is loaded only on STOP.
module bwd_period_hold
  import bwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_seen,
  input  logic [1:0] code_req,
  output period_e    active
);

  always_ff @(posedge clk) begin
    if (rst)
      active <= PER_OFF;
    else if (stop_seen)
      active <= period_e'(code_req);
  end

endmodule

// File: rtl/bwd_timer.sv
// Tick counter with per-code limit, battery freeze and sticky timeout.
module bwd_timer
  import bwd_pkg::*;
#(
  parameter int unsigned T_LONG  = 800,
  parameter int unsigned T_MID   = 400,
  parameter int unsigned T_SHORT = 150,
  parameter int unsigned CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             on_battery,
  input  logic             kick,
  input  period_e          active,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             wdo_n
);

  logic [CNT_W-1:0] count_inc;

  assign count_inc = count + 1'b1;

  always_comb begin
    case (active)
      PER_LONG:  limit = CNT_W'(T_LONG);
      PER_MID:   limit = CNT_W'(T_MID);
      PER_SHORT: limit = CNT_W'(T_SHORT);
      default:   limit = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wdo_n <= 1'b1;
    end else if (active == PER_OFF || kick) begin
      count <= '0;
      wdo_n <= 1'b1;
    end else if (!wdo_n) begin
      count <= count;
    end else if (tick && !on_battery) begin
      if (count_inc >= limit) begin
        count <= limit;
        wdo_n <= 1'b0;
      end else begin
        count <= count_inc;
      end
    end
  end

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int unsigned T_LONG  = 800,
  parameter int unsigned T_MID   = 400,
  parameter int unsigned T_SHORT = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       scl,
  input  logic       sda,
  input  logic       on_battery,
  input  logic [1:0] period_code,
  output logic       wdo_n
);

  localparam int unsigned T_MAX = max3(T_LONG, T_MID, T_SHORT);
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic             kick;
  logic             stop_seen;
  period_e          active;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  bwd_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl),
    .sda       (sda),
    .kick      (kick),
    .stop_seen (stop_seen)
  );

  bwd_period_hold u_period (
    .clk       (clk),
    .rst       (rst),
    .stop_seen (stop_seen),
    .code_req  (period_code),
    .active    (active)
  );

  bwd_timer #(
    .T_LONG  (T_LONG),
    .T_MID   (T_MID),
    .T_SHORT (T_SHORT),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_ms),
    .on_battery (on_battery),
    .kick       (kick),
    .active     (active),
    .count      (count),
    .limit      (limit),
    .wdo_n      (wdo_n)
  );

endmodule

// File: rtl/bus_watchdog_chk.sv
module bus_watchdog_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             on_battery,
  input logic             kick,
  input logic             stop_seen,
  input logic [1:0]       active,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input logic             wdo_n
);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the cycle after reset, timeout is clear and the code is off
  always @(posedge clk) begin
    if (rst_d && !rst)
      p_reset_state_r1: assert (wdo_n && active == 2'b11);
  end

  p_off_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (active == 2'b11) |=> (wdo_n && count == '0));

  p_kick_clears_r6: assert property (@(posedge clk) disable iff (rst)
    kick |=> (wdo_n && count == '0));

  p_battery_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (on_battery && !kick && active != 2'b11) |=> $stable(count));

  p_code_on_stop_r10: assert property (@(posedge clk) disable iff (rst)
    !stop_seen |=> $stable(active));

  p_timeout_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (!wdo_n && !kick && active != 2'b11) |=> !wdo_n);

  p_expire_at_limit_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo_n) |-> (count == limit));

endmodule

bind bus_watchdog bus_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .on_battery (on_battery),
  .kick       (kick),
  .stop_seen  (stop_seen),
  .active     (active),
  .count      (count),
  .limit      (limit),
  .wdo_n      (wdo_n)
);

// File: tb/bus_watchdog_bench.sv
`timescale 1ns/1ps
module bus_watchdog_bench;

  localparam int unsigned TL = 40;
  localparam int unsigned TM = 24;
  localparam int unsigned TS = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       on_battery = 1'b0;
  logic [1:0] period_code = 2'b00;
  logic       wdo_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bus_watchdog #(.T_LONG(TL), .T_MID(TM), .T_SHORT(TS)) u_bus_watchdog (
    .clk         (clk),
    .rst         (rst),
    .tick_ms     (tick_ms),
    .scl         (scl),
    .sda         (sda),
    .on_battery  (on_battery),
    .period_code (period_code),
    .wdo_n       (wdo_n)
  );

  task automatic check_wdo(input logic exp, input string req);
    checks++;
    if (wdo_n !== exp) begin
      fails++;
      $display("FAIL %s: wdo_n=%b expected %b at %0t", req, wdo_n, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      @(negedge clk);
    end
  endtask

  // START then first SCL fall (restart event); lines left low
  task automatic bus_start();
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b0;
    idle(3);
  endtask

  task automatic scl_pulse();
    @(negedge clk); scl = 1'b1;
    @(negedge clk); scl = 1'b0;
    idle(3);
  endtask

  task automatic bus_stop();
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b1;
    idle(3);
  endtask

  task automatic load_code(input logic [1:0] c);
    period_code = c;
    bus_start();
    bus_stop();
  endtask

  task automatic t_reset();
    check_wdo(1'b1, "R1 after reset");
    period_code = 2'b10;
    ticks(TL + 10);
    check_wdo(1'b1, "R1 off until STOP");
    check_wdo(1'b1, "R10 code ignored without STOP");
  endtask

  task automatic t_short();
    load_code(2'b10);
    ticks(TS - 1);
    check_wdo(1'b1, "R4 before limit");
    ticks(1);
    check_wdo(1'b0, "R4 at limit");
    ticks(5);
    check_wdo(1'b0, "R11 stays low");
  endtask

  task automatic t_restart();
    bus_start();
    check_wdo(1'b1, "R6 restart clears timeout");
    ticks(5);
    scl_pulse();
    ticks(TS - 6);
    check_wdo(1'b1, "R7 before limit");
    ticks(1);
    check_wdo(1'b0, "R7 later SCL fall did not restart");
    bus_stop();
  endtask

  task automatic t_no_start();
    @(negedge clk); scl = 1'b0;
    idle(3);
    check_wdo(1'b0, "R8 SCL fall without START");
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    @(negedge clk); scl = 1'b0;
    idle(3);
    check_wdo(1'b0, "R8 SDA fall with SCL low");
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b1;
    idle(3);
  endtask

  task automatic t_battery();
    bus_start();
    check_wdo(1'b1, "R9 restart");
    ticks(3);
    on_battery = 1'b1;
    ticks(TS + 10);
    check_wdo(1'b1, "R9 frozen on battery");
    on_battery = 1'b0;
    ticks(TS - 4);
    check_wdo(1'b1, "R9 resumed before limit");
    ticks(1);
    check_wdo(1'b0, "R9 resumed count reaches limit");
    bus_stop();
  endtask

  task automatic t_mid_long();
    load_code(2'b01);
    ticks(TM - 1);
    check_wdo(1'b1, "R3 before limit");
    ticks(1);
    check_wdo(1'b0, "R3 at limit");
    load_code(2'b00);
    period_code = 2'b10;
    ticks(TL - 1);
    check_wdo(1'b1, "R2 before limit");
    check_wdo(1'b1, "R10 mid change not applied");
    ticks(1);
    check_wdo(1'b0, "R2 at limit");
  endtask

  task automatic t_off();
    load_code(2'b11);
    check_wdo(1'b1, "R5 off clears timeout");
    ticks(TL + 20);
    check_wdo(1'b1, "R5 off never expires");
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_short();
    t_restart();
    t_no_start();
    t_battery();
    t_mid_long();
    t_off();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, cycles=%0d expected <= 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule